// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the configuration of a bank of general-purpose pads behind a simple 32-bit register bus. Two register layouts share one address space. Bank-wide bitmaps keep one bit per pin, packed into consecutive 32-bit words. Per-pin configuration pairs keep each pad's settings in two words: a control word and a pad-electrical word. The block drives every pad's output level, output enable, weak pull and input-sense gate. It passes trigger-kind and polarity fields on to a separate interrupt detector. It returns the synchronised pad input level on reads.

The bus presents a byte address, a write flag and write data for one cycle. Read data is registered and appears on the cycle after the request. It then holds until the next read. The interrupt detector reports events on `irq_event`. Each event sets a status bit, and software clears that bit by writing a one to it. The pin count and address width are parameters. The default is 95 pins, so each bitmap spans three words and the last word has 31 live bits.

The bank is split into four parts: an address decoder, a bitmap register used for all four maps, a per-pin configuration store, and a two-flop input synchroniser. The top module holds the read multiplexer and the registered read port. The block has no state machine. Every register updates directly from the decoded bus write.

Top module: `gpb_bank`

## Requirements
- R1: After reset every bitmap bit is 0. Each pin's control word reads 0x00000004 (input direction, native usage, level field 0). Each pin's electrical word reads 0x00000004 (input sense off, no pull). `pad_oe`, `pad_out`, `pad_sense_en`, `pad_pull_up` and `pad_pull_dn` are all 0.
- R2: Four bitmaps sit at word base + (pin/32)*4, using bit pin%32: ownership at 0x00, redirection at 0x10, interrupt status at 0x80 and interrupt enable at 0x90. Ownership, redirection and enable are read/write, and each drives its own output vector.
- R3: Bits of the last bitmap word above the highest pin (bit 31 of word 2 at 95 pins) read 0 and ignore writes.
- R4: The control word of pin p is at 0x100 + 8*p. Bit 31 is the output level, bit 4 the trigger kind (1 level), bit 3 the polarity invert, bit 2 the direction (1 input) and bits 1:0 the usage (1 GPIO). All five fields are read/write. Bits 29:5 read 0. Bits 4 and 3 drive `pin_trig_level` and `pin_trig_invert`, and bit 31 drives `pad_out`.
- R5: The electrical word of pin p is at 0x104 + 8*p. Bit 2 turns input sensing off, and bits 1:0 select the pull: 1 pulls down, 2 pulls up, 0 and 3 select none. Bits 31:3 read 0. `pad_sense_en` is the inverse of bit 2.
- R6: `pad_oe[p]` is 1 exactly when the usage field of pin p equals 1 and its direction bit is 0.
- R7: Bit 30 of the control word is read-only and ignores writes. It returns `pad_in[p]` through a two-flop synchroniser. A pad change driven before clock edge k is first seen by a read request sampled at edge k+2.
- R8: While input sensing of a pin is off, bit 30 of its control word reads 0 whatever the pad does.
- R9: An `irq_event[p]` pulse sets status bit p. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event wins over a clear in the same cycle.
- R10: Unmapped addresses read 0 and ignore writes. These include 0x0C, 0x20, 0xA0 and any per-pin address at or beyond pin NUM_PINS. Address bits 1:0 are ignored.
- R11: `bus_rdata` changes only in response to a read request, one cycle later. It holds across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| irq_event | input | NUM_PINS | Event pulses from the interrupt detector |
| pad_out | output | NUM_PINS | Driven output level |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pull_up | output | NUM_PINS | Weak pull-up select |
| pad_pull_dn | output | NUM_PINS | Weak pull-down select |
| pad_sense_en | output | NUM_PINS | Input receiver enable |
| pin_trig_level | output | NUM_PINS | Trigger kind, 1 level |
| pin_trig_invert | output | NUM_PINS | Trigger polarity invert |
| pin_owned | output | NUM_PINS | Ownership map |
| pin_redirect | output | NUM_PINS | Redirection map |
| irq_status | output | NUM_PINS | Interrupt status map |
| irq_enable | output | NUM_PINS | Interrupt enable map |

## Verification
The bench writes and reads back every pin's two words and every word of each bitmap. It checks the whole pad vectors against expected values computed arithmetically, so a stride of 4 instead of 8, or a swapped word, shows up as a wrong readback or a wrong pin's output. It aims at the 31-bit last bitmap word, where a design would otherwise store or return a phantom bit 31. It also checks that writes to bit 30 cannot fake a pad level. Three reads in a row around one pad edge pin the synchroniser to exactly two stages, exposing both a missing flop and an extra one. The same-cycle event-and-clear case catches a status register that gives the software clear priority and loses an interrupt.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int BUS_W     = 32;
    localparam int CFG_BASE  = 32'h100;
    localparam int MAP_COUNT = 4;

    // control word field positions (the interrupt detector decodes 4 and 3)
    localparam int A_OUT  = 31;
    localparam int A_IN   = 30;
    localparam int A_TRIG = 4;
    localparam int A_INV  = 3;
    localparam int A_DIR  = 2;
    localparam logic [1:0] USE_GPIO = 2'd1;

    // electrical word field positions
    localparam int B_NOSENSE = 2;
    localparam logic [1:0] PULL_DN = 2'd1;
    localparam logic [1:0] PULL_UP = 2'd2;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_OWNER,
        TGT_ROUTE,
        TGT_STAT,
        TGT_IEN,
        TGT_CFGA,
        TGT_CFGB
    } tgt_e;

    typedef struct packed {
        tgt_e        tgt;
        logic [1:0]  word;
        logic [15:0] pin;
    } dec_t;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic [1:0] use_sel;
    } cfg_a_t;

    typedef struct packed {
        logic       nosense;
        logic [1:0] pull;
    } cfg_b_t;

    localparam cfg_a_t CFG_A_RST = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                                     dir_in: 1'b1, use_sel: 2'd0};
    localparam cfg_b_t CFG_B_RST = '{nosense: 1'b1, pull: 2'd0};

    function automatic tgt_e map_tgt(input int idx);
        case (idx)
            0:       return TGT_OWNER;
            1:       return TGT_ROUTE;
            2:       return TGT_STAT;
            default: return TGT_IEN;
        endcase
    endfunction

    function automatic int map_base(input int idx);
        case (idx)
            0:       return 32'h00;
            1:       return 32'h10;
            2:       return 32'h80;
            default: return 32'h90;
        endcase
    endfunction

endpackage

// File: rtl/gpb_addr_dec.sv
module gpb_addr_dec
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 95,
    parameter int ADDR_W   = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int WORDS = (NUM_PINS + 31) / 32;

    logic [ADDR_W-1:0] cfg_off;

    always_comb begin
        dec     = '{tgt: TGT_NONE, word: 2'd0, pin: 16'd0};
        cfg_off = addr - ADDR_W'(CFG_BASE);
        if (int'(addr) >= CFG_BASE) begin
            if (int'(cfg_off >> 3) < NUM_PINS) begin
                dec.tgt = addr[2] ? TGT_CFGB : TGT_CFGA;
                dec.pin = 16'(cfg_off >> 3);
            end
        end else begin
            for (int m = 0; m < MAP_COUNT; m++) begin
                if (addr[ADDR_W-1:4] == (ADDR_W-4)'(map_base(m) >> 4) &&
                    int'(addr[3:2]) < WORDS) begin
                    dec.tgt  = map_tgt(m);
                    dec.word = addr[3:2];
                end
            end
        end
    end

endmodule

// File: rtl/gpb_bitmap_reg.sv
module gpb_bitmap_reg #(
    parameter int NUM_PINS     = 95,
    parameter bit CLEAR_ON_ONE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_word,
    input  logic [31:0]         wr_data,
    input  logic [NUM_PINS-1:0] set_i,
    output logic [NUM_PINS-1:0] q
);

    for (genvar b = 0; b < NUM_PINS; b++) begin : g_bit
        localparam int WI = b / 32;
        localparam int BI = b % 32;
        logic bit_q;
        logic hit;

        assign hit  = wr_en && (wr_word == 2'(WI));
        assign q[b] = bit_q;

        if (CLEAR_ON_ONE) begin : g_w1c
            always_ff @(posedge clk) begin
                if (!rst_n)                    bit_q <= 1'b0;
                else if (set_i[b])             bit_q <= 1'b1;
                else if (hit && wr_data[BI])   bit_q <= 1'b0;
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (!rst_n)         bit_q <= 1'b0;
                else if (set_i[b])  bit_q <= 1'b1;
                else if (hit)       bit_q <= wr_data[BI];
            end
        end

        // R9: an event always leaves the bit set, even against a clear
        a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> q[b]);
    end

endmodule

// File: rtl/gpb_sync2.sv
module gpb_sync2 #(
    parameter int WIDTH = 95
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpb_pad_cfg.sv
module gpb_pad_cfg
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 95
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_a,
    input  logic                wr_b,
    input  logic [15:0]         wr_pin,
    input  cfg_a_t              wr_a_val,
    input  cfg_b_t              wr_b_val,
    output cfg_a_t              a_q [NUM_PINS],
    output cfg_b_t              b_q [NUM_PINS],
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pull_up,
    output logic [NUM_PINS-1:0] pull_dn,
    output logic [NUM_PINS-1:0] nosense,
    output logic [NUM_PINS-1:0] trig_lvl,
    output logic [NUM_PINS-1:0] trig_inv
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic sel;
        assign sel = (wr_pin == 16'(p));

        always_ff @(posedge clk) begin
            if (!rst_n)           a_q[p] <= CFG_A_RST;
            else if (wr_a && sel) a_q[p] <= wr_a_val;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)           b_q[p] <= CFG_B_RST;
            else if (wr_b && sel) b_q[p] <= wr_b_val;
        end

        assign pad_out[p]  = a_q[p].out_lvl;
        assign pad_oe[p]   = (a_q[p].use_sel == USE_GPIO) && !a_q[p].dir_in;
        assign pull_up[p]  = (b_q[p].pull == PULL_UP);
        assign pull_dn[p]  = (b_q[p].pull == PULL_DN);
        assign nosense[p]  = b_q[p].nosense;
        assign trig_lvl[p] = a_q[p].trig_lvl;
        assign trig_inv[p] = a_q[p].trig_inv;
    end

endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int NUM_PINS = 95,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] irq_event,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pull_up,
    output logic [NUM_PINS-1:0] pad_pull_dn,
    output logic [NUM_PINS-1:0] pad_sense_en,
    output logic [NUM_PINS-1:0] pin_trig_level,
    output logic [NUM_PINS-1:0] pin_trig_invert,
    output logic [NUM_PINS-1:0] pin_owned,
    output logic [NUM_PINS-1:0] pin_redirect,
    output logic [NUM_PINS-1:0] irq_status,
    output logic [NUM_PINS-1:0] irq_enable
);
    localparam int WORDS = (NUM_PINS + 31) / 32;
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    dec_t              dec;
    logic [PIN_W-1:0]  pin_i;
    logic              wr;
    logic              rd;
    cfg_a_t            wr_a_val;
    cfg_b_t            wr_b_val;
    cfg_a_t            a_q [NUM_PINS];
    cfg_b_t            b_q [NUM_PINS];
    logic [NUM_PINS-1:0] nosense;
    logic [NUM_PINS-1:0] in_sync;
    logic [NUM_PINS-1:0] sensed;
    logic [NUM_PINS-1:0] map_q [MAP_COUNT];
    logic [WORDS*32-1:0] map_pad;
    logic [31:0]         rd_mux;

    assign wr    = bus_valid && bus_write;
    assign rd    = bus_valid && !bus_write;
    assign pin_i = PIN_W'(dec.pin);

    gpb_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // ---------------- bitmaps ----------------
    for (genvar g = 0; g < MAP_COUNT; g++) begin : g_map
        localparam tgt_e G_TGT = map_tgt(g);
        logic [NUM_PINS-1:0] set_v;
        if (G_TGT == TGT_STAT) begin : g_evt
            assign set_v = irq_event;
        end else begin : g_noevt
            assign set_v = {NUM_PINS{1'b0}};
        end
        gpb_bitmap_reg #(.NUM_PINS(NUM_PINS), .CLEAR_ON_ONE(G_TGT == TGT_STAT)) u_map (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr && (dec.tgt == G_TGT)),
            .wr_word (dec.word),
            .wr_data (bus_wdata),
            .set_i   (set_v),
            .q       (map_q[g])
        );
    end

    assign pin_owned    = map_q[0];
    assign pin_redirect = map_q[1];
    assign irq_status   = map_q[2];
    assign irq_enable   = map_q[3];

    // ---------------- per-pin configuration ----------------
    assign wr_a_val = '{out_lvl:  bus_wdata[A_OUT],
                        trig_lvl: bus_wdata[A_TRIG],
                        trig_inv: bus_wdata[A_INV],
                        dir_in:   bus_wdata[A_DIR],
                        use_sel:  bus_wdata[1:0]};
    assign wr_b_val = '{nosense: bus_wdata[B_NOSENSE],
                        pull:    bus_wdata[1:0]};

    gpb_pad_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_a     (wr && (dec.tgt == TGT_CFGA)),
        .wr_b     (wr && (dec.tgt == TGT_CFGB)),
        .wr_pin   (dec.pin),
        .wr_a_val (wr_a_val),
        .wr_b_val (wr_b_val),
        .a_q      (a_q),
        .b_q      (b_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pull_up  (pad_pull_up),
        .pull_dn  (pad_pull_dn),
        .nosense  (nosense),
        .trig_lvl (pin_trig_level),
        .trig_inv (pin_trig_invert)
    );

    assign pad_sense_en = ~nosense;

    // ---------------- input path ----------------
    gpb_sync2 #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    assign sensed = in_sync & ~nosense;

    // ---------------- read path ----------------
    always_comb begin
        map_pad = '0;
        rd_mux  = '0;
        for (int m = 0; m < MAP_COUNT; m++) begin
            if (dec.tgt == map_tgt(m)) map_pad[NUM_PINS-1:0] = map_q[m];
        end
        case (dec.tgt)
            TGT_OWNER, TGT_ROUTE, TGT_STAT, TGT_IEN: begin
                rd_mux = map_pad[32*dec.word +: 32];
            end
            TGT_CFGA: begin
                rd_mux[A_OUT]  = a_q[pin_i].out_lvl;
                rd_mux[A_IN]   = sensed[pin_i];
                rd_mux[A_TRIG] = a_q[pin_i].trig_lvl;
                rd_mux[A_INV]  = a_q[pin_i].trig_inv;
                rd_mux[A_DIR]  = a_q[pin_i].dir_in;
                rd_mux[1:0]    = a_q[pin_i].use_sel;
            end
            TGT_CFGB: begin
                rd_mux[B_NOSENSE] = b_q[pin_i].nosense;
                rd_mux[1:0]       = b_q[pin_i].pull;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end

    // ---------------- assertions ----------------
    // R6: a control write decides the pin's output enable on the next cycle
    a_r6_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && dec.tgt == TGT_CFGA) |=>
            (pad_oe[$past(pin_i)] ==
             (($past(bus_wdata[1:0]) == USE_GPIO) && !$past(bus_wdata[A_DIR]))));

    // R8: a pin with sensing off never reports a high input level
    a_r8_nosense_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && dec.tgt == TGT_CFGA && !pad_sense_en[pin_i]) |=> !bus_rdata[A_IN]);

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && dec.tgt == TGT_NONE) |=> (bus_rdata == 32'd0));

    // R11: read data only moves after a read request
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));

endmodule

// File: tb/gpb_bank_tb_top.sv
`timescale 1ns/1ps
module gpb_bank_tb_top;
    localparam int N  = 95;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [N-1:0]  pad_in, irq_event;
    logic [N-1:0]  pad_out, pad_oe, pad_pull_up, pad_pull_dn, pad_sense_en;
    logic [N-1:0]  pin_trig_level, pin_trig_invert;
    logic [N-1:0]  pin_owned, pin_redirect, irq_status, irq_enable;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpb_bank #(.NUM_PINS(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .irq_event(irq_event), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
        .pad_sense_en(pad_sense_en), .pin_trig_level(pin_trig_level),
        .pin_trig_invert(pin_trig_invert), .pin_owned(pin_owned),
        .pin_redirect(pin_redirect), .irq_status(irq_status), .irq_enable(irq_enable)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chkv(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(addr);
        @(negedge clk);
        bus_valid = 1'b0;
        data = bus_rdata;
    endtask

    function automatic logic [31:0] pat_a(input int p);
        return (32'(p) * 32'h9E3779B9) ^ 32'h4000_0013;
    endfunction

    function automatic logic [31:0] pat_b(input int p);
        return 32'((p * 5 + 1) % 8) ^ 32'hABCD_0000;
    endfunction

    function automatic logic [31:0] bpat(input int r, input int w);
        return 32'hA5C3_0F96 ^ (32'(r) * 32'h1111_1111) ^ (32'(w) * 32'h0101_0101);
    endfunction

    function automatic int base_of(input int r);
        case (r)
            0:       return 32'h00;
            1:       return 32'h10;
            2:       return 32'h80;
            default: return 32'h90;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        logic [95:0] ev;
        logic [N-1:0] e_oe, e_out, e_trig, e_inv, e_up, e_dn, e_sense;
        logic [N-1:0] s_own, s_red, s_ien, s_stat;

        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
        bus_wdata = '0; pad_in = '0; irq_event = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // ---- R1 reset state ----
        chkv("R1 reset pad_oe", 128'(pad_oe), 128'd0);
        chkv("R1 reset pad_out", 128'(pad_out), 128'd0);
        chkv("R1 reset sense", 128'(pad_sense_en), 128'd0);
        chkv("R1 reset pulls", 128'(pad_pull_up | pad_pull_dn), 128'd0);
        chkv("R1 reset maps", 128'(pin_owned | pin_redirect | irq_status | irq_enable), 128'd0);
        rd(32'h100, d);             chk("R1 reset ctrl pin0", d, 32'h4);
        rd(32'h104 + 8 * 94, d);    chk("R1 reset elec pin94", d, 32'h4);
        rd(32'h100 + 8 * 94, d);    chk("R1 reset ctrl pin94", d, 32'h4);
        rd(32'h90, d);              chk("R1 reset enable w0", d, 32'h0);

        // ---- R2 / R3 bitmap sweep (status handled under R9) ----
        for (int r = 0; r < 4; r++) begin
            if (r != 2) begin
                for (int w = 0; w < 3; w++) wr(base_of(r) + 4 * w, bpat(r, w));
                for (int w = 0; w < 3; w++) begin
                    rd(base_of(r) + 4 * w, d);
                    chk($sformatf("R2 map %0d word %0d", r, w), d,
                        (w == 2) ? (bpat(r, w) & 32'h7FFF_FFFF) : bpat(r, w));
                end
                for (int w = 0; w < 3; w++) ev[32 * w +: 32] = bpat(r, w);
                case (r)
                    0:       chkv("R2 owned vector", 128'(pin_owned), 128'(ev[N-1:0]));
                    1:       chkv("R2 redirect vector", 128'(pin_redirect), 128'(ev[N-1:0]));
                    default: chkv("R2 enable vector", 128'(irq_enable), 128'(ev[N-1:0]));
                endcase
            end
        end
        wr(32'h08, 32'hFFFF_FFFF);
        rd(32'h08, d);
        chk("R3 top word bit31 reads 0", d, 32'h7FFF_FFFF);
        chk("R3 pin94 owned", 32'(pin_owned[94]), 32'd1);

        // ---- R4 / R5 / R6 / R8 per-pin sweep ----
        for (int p = 0; p < N; p++) wr(32'h100 + 8 * p, pat_a(p));
        for (int p = 0; p < N; p++) wr(32'h104 + 8 * p, pat_b(p));
        pad_in = '1;
        repeat (3) @(negedge clk);
        for (int p = 0; p < N; p++) begin
            logic [31:0] a, b;
            a = pat_a(p) & 32'h8000_001F;
            b = pat_b(p) & 32'h7;
            e_oe[p]    = (a[1:0] == 2'd1) && !a[2];
            e_out[p]   = a[31];
            e_trig[p]  = a[4];
            e_inv[p]   = a[3];
            e_sense[p] = !b[2];
            e_up[p]    = (b[1:0] == 2'd2);
            e_dn[p]    = (b[1:0] == 2'd1);
            rd(32'h100 + 8 * p, d);
            chk($sformatf("R4 R8 ctrl pin %0d", p), d, a | (e_sense[p] ? 32'h4000_0000 : 32'h0));
            rd(32'h104 + 8 * p, d);
            chk($sformatf("R5 elec pin %0d", p), d, b);
        end
        chkv("R6 pad_oe vector", 128'(pad_oe), 128'(e_oe));
        chkv("R4 pad_out vector", 128'(pad_out), 128'(e_out));
        chkv("R4 trig level vector", 128'(pin_trig_level), 128'(e_trig));
        chkv("R4 trig invert vector", 128'(pin_trig_invert), 128'(e_inv));
        chkv("R5 pull up vector", 128'(pad_pull_up), 128'(e_up));
        chkv("R5 pull down vector", 128'(pad_pull_dn), 128'(e_dn));
        chkv("R5 R8 sense vector", 128'(pad_sense_en), 128'(e_sense));

        // R6 explicit: GPIO usage, output direction on pin 7
        wr(32'h100 + 8 * 7, 32'h0000_0001);
        chk("R6 gpio output enables", 32'(pad_oe[7]), 32'd1);
        wr(32'h100 + 8 * 7, 32'h0000_0002);
        chk("R6 native usage disables", 32'(pad_oe[7]), 32'd0);

        // ---- R7 read-only bit and synchroniser depth on pin 0 ----
        wr(32'h104, 32'h0);
        pad_in = '0;
        repeat (3) @(negedge clk);
        wr(32'h100, 32'h4000_0004);
        rd(32'h100, d);
        chk("R7 bit30 write ignored", d, 32'h0000_0004);
        @(negedge clk);
        pad_in[0] = 1'b1; bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(32'h100);
        @(negedge clk); chk("R7 edge+1 still low", 32'(bus_rdata[30]), 32'd0);
        @(negedge clk); chk("R7 edge+2 read still low", 32'(bus_rdata[30]), 32'd0);
        @(negedge clk); bus_valid = 1'b0;
        chk("R7 third read sees pad", 32'(bus_rdata[30]), 32'd1);
        // R8: turning sensing off hides a high pad
        wr(32'h104, 32'h4);
        rd(32'h100, d);
        chk("R8 sense off reads low", 32'(d[30]), 32'd0);

        // ---- R9 status set / clear ----
        @(negedge clk);
        irq_event = '0; irq_event[3] = 1'b1; irq_event[40] = 1'b1; irq_event[94] = 1'b1;
        @(negedge clk);
        irq_event = '0;
        rd(32'h80, d); chk("R9 status w0", d, 32'h0000_0008);
        rd(32'h84, d); chk("R9 status w1", d, 32'h0000_0100);
        rd(32'h88, d); chk("R9 status w2", d, 32'h4000_0000);
        wr(32'h84, 32'h0);
        chk("R9 write zero keeps pin40", 32'(irq_status[40]), 32'd1);
        wr(32'h80, 32'h8);
        chk("R9 write one clears pin3", 32'(irq_status[3]), 32'd0);
        @(negedge clk);
        irq_event[3] = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(32'h80); bus_wdata = 32'h8;
        @(negedge clk);
        irq_event = '0; bus_valid = 1'b0; bus_write = 1'b0;
        chk("R9 event beats clear", 32'(irq_status[3]), 32'd1);

        // ---- R10 unmapped space ----
        s_own = pin_owned; s_red = pin_redirect; s_ien = irq_enable; s_stat = irq_status;
        wr(32'h0C, 32'hFFFF_FFFF);
        wr(32'h20, 32'hFFFF_FFFF);
        wr(32'hA0, 32'hFFFF_FFFF);
        wr(32'h100 + 8 * N, 32'hFFFF_FFFF);
        rd(32'h0C, d); chk("R10 0x0C reads 0", d, 32'h0);
        rd(32'h20, d); chk("R10 0x20 reads 0", d, 32'h0);
        rd(32'hA0, d); chk("R10 0xA0 reads 0", d, 32'h0);
        rd(32'h100 + 8 * N, d); chk("R10 pin beyond range reads 0", d, 32'h0);
        chkv("R10 maps unchanged",
             {s_own[31:0], s_red[31:0], s_ien[31:0], s_stat[31:0]},
             {pin_owned[31:0], pin_redirect[31:0], irq_enable[31:0], irq_status[31:0]});
        chkv("R10 top words unchanged", 128'({s_own[94:32], s_ien[94:32]}),
             128'({pin_owned[94:32], irq_enable[94:32]}));
        rd(32'h100 + 8 * 9, d);
        rd(32'h103 + 8 * 9, d2);
        chk("R10 low address bits ignored", d2, d);

        // ---- R11 read data hold ----
        rd(32'h04, d);
        wr(32'h94, 32'h0);
        chk("R11 hold across write", bus_rdata, d);
        repeat (3) @(negedge clk);
        chk("R11 hold across idle", bus_rdata, d);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule